// File: doc/BRIEF.md
# Hash Message Word Ingest Counter

This block sits in front of a hash core and takes in the message one 32-bit word per write. It puts the four bytes of each word into the sequence chosen by a 2-bit byte-order mode, then hands them to the core one byte at a time over a valid/ready stream. The write port carries no byte mask. The block therefore counts accepted bytes against a programmed message length, given in bits, to decide how many bytes of the final word are message and how many are padding. Padding bytes are dropped.

Configuration arrives as a one-cycle strobe that carries the mode and the length. The strobe also starts a short guard window. A data write made before any configuration, inside the guard window, or after the message is complete is dropped and reported with a one-cycle error pulse. When the last message byte leaves the stream, a one-cycle done pulse is raised. A zero-length message raises the done pulse straight from configuration.

Back-pressure rules. The write port is stalled (`wr_ready` low) whenever a word is held and has bytes that have not yet left the stream. A word is taken only in a cycle where `wr_valid` and `wr_ready` are both high. On the output side, `out_valid` is never withdrawn and `out_data` never changes until the byte is taken with `out_ready`. A new configuration is the only exception: it discards the held bytes.

Top module: `hash_word_ingest`

## Requirements
- R1: After reset, `out_valid`, `msg_done` and `wr_err` are low and `wr_ready` is high.
- R2: Byte lane L of a word is bits 8L+7..8L. For each `cfg_order` value, the lanes leave the stream in this order: order 0 sends lanes 0,1,2,3; order 1 sends lanes 3,2,1,0; order 2 sends lanes 0,1,3,2; order 3 sends lanes 2,3,0,1.
- R3: The message holds floor(`cfg_len_bits`/8) bytes, and the bits below a whole byte are ignored. Every word except the last yields all four bytes. The last word yields only the first remaining-count bytes of its sequence from R2, and its other bytes are never presented.
- R4: A write accepted when no configuration has been seen since reset produces no output byte and pulses `wr_err` for one cycle, in the cycle after the write.
- R5: A write accepted in the same cycle as `cfg_valid`, or in the cycle right after it, is dropped with a `wr_err` pulse. A write accepted two or more cycles after `cfg_valid` counts as message data.
- R6: `msg_done` pulses for exactly one cycle, in the cycle after the final message byte is taken. Every write after that, until the next configuration, is dropped with a `wr_err` pulse.
- R7: If a configuration gives fewer than 8 length bits, `msg_done` pulses in the cycle right after `cfg_valid`.
- R8: While `out_valid` is high, `wr_ready` is low. While `out_valid` is high and `out_ready` is low, `out_data` holds its value.
- R9: Words written back to back in every cycle produce the same byte stream as words written with idle cycles between them.
- R10: `cfg_valid` discards any held bytes. `out_valid` is low in the cycle after it, and the new message starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | One-cycle configuration strobe |
| cfg_order | input | 2 | Byte-order mode (R2) |
| cfg_len_bits | input | LEN_W | Message length in bits |
| wr_valid | input | 1 | Data word offered |
| wr_data | input | 32 | Data word |
| wr_ready | output | 1 | Block can take a word |
| out_valid | output | 1 | Byte offered to hash core |
| out_ready | input | 1 | Hash core takes byte |
| out_data | output | 8 | Message byte |
| msg_done | output | 1 | One-cycle end-of-message pulse |
| wr_err | output | 1 | One-cycle dropped-write pulse |

## Verification
The bench sweeps every byte-order mode against byte counts from 0 to 13, so that the final word is cut at each of its 0 to 3 remaining lanes. It adds sub-byte length bits, which must not change the byte count. Each case is run both with back-to-back writes and with spaced writes, and with the output either always ready or randomly stalled. This separates a wrong lane order from a wrong padding cut and from handshake loss. Directed cases cover writes before configuration, writes inside the guard window, writes after completion, a held word under full back-pressure, and a reconfiguration that lands on a held word.

// File: rtl/hash_word_ingest_pkg.sv
`timescale 1ns/1ps
package hash_word_ingest_pkg;
  localparam int WORD_BYTES = 4;
  localparam int CNT_W      = $clog2(WORD_BYTES + 1);

  typedef logic [WORD_BYTES-1:0][7:0] byte_seq_t;

  // Lane emitted at sequence position pos for each byte-order mode.
  function automatic logic [1:0] lane_at(input logic [1:0] ord, input logic [1:0] pos);
    case (ord)
      2'd0:    lane_at = pos;
      2'd1:    lane_at = 2'd3 - pos;
      2'd2:    lane_at = pos[1] ? (pos ^ 2'd1) : pos;
      default: lane_at = pos ^ 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/hwi_reorder.sv
`timescale 1ns/1ps
module hwi_reorder
  import hash_word_ingest_pkg::*;
(
  input  logic [1:0]  order,
  input  logic [31:0] word,
  output byte_seq_t   seq
);
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_pos
    assign seq[g] = word[8*int'(lane_at(order, 2'(g))) +: 8];
  end
endmodule

// File: rtl/hwi_drain.sv
`timescale 1ns/1ps
module hwi_drain
  import hash_word_ingest_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  byte_seq_t        load_seq,
  input  logic [CNT_W-1:0] load_n,
  input  logic             pop,
  output logic [7:0]       head,
  output logic [CNT_W-1:0] cnt
);
  byte_seq_t hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      cnt    <= '0;
    end else if (clr) begin
      cnt    <= '0;
    end else if (load) begin
      hold_q <= load_seq;
      cnt    <= load_n;
    end else if (pop) begin
      for (int i = 0; i < WORD_BYTES - 1; i++) hold_q[i] <= hold_q[i+1];
      hold_q[WORD_BYTES-1] <= 8'h00;
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign head = hold_q[0];
endmodule

// File: rtl/hwi_ctrl.sv
`timescale 1ns/1ps
module hwi_ctrl
  import hash_word_ingest_pkg::*;
#(
  parameter int LEN_W   = 32,
  parameter int GAP_CYC = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [1:0]       cfg_order,
  input  logic [LEN_W-1:0] cfg_len_bits,
  input  logic             wr_fire,
  input  logic             last_pop,
  output logic             load,
  output logic [CNT_W-1:0] load_n,
  output logic [1:0]       order_q,
  output logic             msg_done,
  output logic             wr_err
);
  localparam int BYTE_W = LEN_W - 3;
  localparam int GW     = $clog2(GAP_CYC + 1);

  logic              cfgd;
  logic [GW-1:0]     gap;
  logic [BYTE_W-1:0] rem;
  logic [BYTE_W-1:0] new_bytes;
  logic              legal;

  assign new_bytes = BYTE_W'(cfg_len_bits >> 3);
  assign legal     = cfgd && (gap == '0) && (rem != '0) && !cfg_valid;
  assign load      = wr_fire && legal;
  assign load_n    = (rem >= BYTE_W'(WORD_BYTES)) ? CNT_W'(WORD_BYTES) : CNT_W'(rem);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgd     <= 1'b0;
      gap      <= '0;
      rem      <= '0;
      order_q  <= '0;
      msg_done <= 1'b0;
      wr_err   <= 1'b0;
    end else begin
      wr_err   <= wr_fire && !legal;
      msg_done <= 1'b0;
      if (cfg_valid) begin
        cfgd     <= 1'b1;
        gap      <= GW'(GAP_CYC - 1);
        rem      <= new_bytes;
        order_q  <= cfg_order;
        msg_done <= (new_bytes == '0);
      end else begin
        if (gap != '0) gap <= gap - GW'(1);
        if (load) rem <= rem - BYTE_W'(load_n);
        if (last_pop && rem == '0) msg_done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hash_word_ingest.sv
`timescale 1ns/1ps
module hash_word_ingest
  import hash_word_ingest_pkg::*;
#(
  parameter int LEN_W   = 32,
  parameter int GAP_CYC = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [1:0]       cfg_order,
  input  logic [LEN_W-1:0] cfg_len_bits,
  input  logic             wr_valid,
  input  logic [31:0]      wr_data,
  output logic             wr_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             msg_done,
  output logic             wr_err
);
  logic             wr_fire, pop, last_pop, load;
  logic [CNT_W-1:0] load_n, cnt;
  logic [1:0]       order_q;
  byte_seq_t        seq;

  assign wr_ready  = (cnt == '0);
  assign out_valid = (cnt != '0);
  assign wr_fire   = wr_valid && wr_ready;
  assign pop       = out_valid && out_ready;
  assign last_pop  = pop && (cnt == CNT_W'(1));

  hwi_ctrl #(.LEN_W(LEN_W), .GAP_CYC(GAP_CYC)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_order(cfg_order),
    .cfg_len_bits(cfg_len_bits), .wr_fire(wr_fire), .last_pop(last_pop),
    .load(load), .load_n(load_n), .order_q(order_q),
    .msg_done(msg_done), .wr_err(wr_err)
  );

  hwi_reorder reorder_i (.order(order_q), .word(wr_data), .seq(seq));

  hwi_drain drain_i (
    .clk(clk), .rst_n(rst_n), .clr(cfg_valid), .load(load), .load_seq(seq),
    .load_n(load_n), .pop(pop), .head(out_data), .cnt(cnt)
  );
endmodule

// File: rtl/hash_word_ingest_chk.sv
`timescale 1ns/1ps
module hash_word_ingest_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_valid,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       msg_done,
  input logic       wr_err
);
  logic seen_cfg;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_cfg <= 1'b0;
    else if (cfg_valid) seen_cfg <= 1'b1;
  end

  a_r8_stall_write: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !wr_ready);
  a_r8_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cfg_valid) |=> (out_valid && $stable(out_data)));
  a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_valid && wr_ready));
  a_r4_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !seen_cfg && !cfg_valid) |=> wr_err);
  a_r5_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && (cfg_valid || $past(cfg_valid))) |=> wr_err);
  a_r6_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> !out_valid);
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && !cfg_valid) |=> !msg_done);
  a_r10_cfg_flush: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> !out_valid);
endmodule

bind hash_word_ingest hash_word_ingest_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .msg_done(msg_done), .wr_err(wr_err)
);

// File: tb/hash_word_ingest_tb_top.sv
`timescale 1ns/1ps
module hash_word_ingest_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [1:0]  cfg_order = 2'd0;
  logic [31:0] cfg_len_bits = '0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, out_valid, msg_done, wr_err;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;

  int compared = 0, mismatched = 0, n_done = 0, n_err = 0, cyc = 0;
  int rdy_mode = 0;
  logic [7:0] got[$];

  always #2.5 clk = ~clk;

  hash_word_ingest dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_order(cfg_order),
    .cfg_len_bits(cfg_len_bits), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .msg_done(msg_done), .wr_err(wr_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = ($urandom % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) got.push_back(out_data);
      if (msg_done) n_done++;
      if (wr_err) n_err++;
    end
  end

  function automatic int lane_of(input int m, input int p);
    case (m)
      0: return p;
      1: return 3 - p;
      2: return (p < 2) ? p : (p ^ 1);
      default: return p ^ 2;
    endcase
  endfunction

  function automatic logic [31:0] mk_word(input int k, input int salt);
    logic [31:0] w;
    for (int l = 0; l < 4; l++) w[8*l +: 8] = 8'((k*4 + l)*29 + salt*13 + 5);
    return w;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  // Returns just after the configuration edge.
  task automatic configure(input int m, input int bits);
    got.delete(); n_done = 0; n_err = 0;
    cfg_valid = 1'b1; cfg_order = 2'(m); cfg_len_bits = 32'(bits);
    @(posedge clk); #1;
    cfg_valid = 1'b0;
  endtask

  task automatic write_word(input logic [31:0] d);
    wr_valid = 1'b1; wr_data = d;
    do @(negedge clk); while (!wr_ready);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int w = 0; w < 300 && n_done == 0; w++) idle(1);
  endtask

  task automatic check_stream(input int m, input int nb, input int salt, input string tag);
    int bad = 0, first_act = 0, first_exp = 0;
    chk(got.size() == nb, {tag, " R3 byte count"}, got.size(), nb);
    for (int i = 0; i < nb && i < got.size(); i++) begin
      logic [31:0] w = mk_word(i / 4, salt);
      logic [7:0] e = w[8*lane_of(m, i % 4) +: 8];
      if (got[i] !== e) begin
        if (bad == 0) begin first_act = got[i]; first_exp = e; end
        bad++;
      end
    end
    chk(bad == 0, {tag, " R2 R9 byte order"}, first_act, first_exp);
  endtask

  task automatic run_msg(input int m, input int nb, input bit spaced, input int salt);
    int words = (nb + 3) / 4;
    configure(m, nb*8 + (nb % 8));
    if (nb == 0) chk(msg_done == 1'b1, "R7 zero-length done timing", msg_done, 1);
    idle(1);
    for (int k = 0; k < words; k++) begin
      write_word(mk_word(k, salt));
      if (spaced) idle(3);
    end
    wait_done();
    idle(2);
    write_word(mk_word(9, salt));
    idle(3);
    check_stream(m, nb, salt, spaced ? "spaced" : "burst");
    chk(n_done == 1, "R6 R7 single done pulse", n_done, 1);
    chk(n_err == 1, "R6 write after done flagged", n_err, 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && msg_done == 0 && wr_err == 0, "R1 reset outputs idle",
        {out_valid, msg_done, wr_err}, 0);
    chk(wr_ready == 1, "R1 reset wr_ready", wr_ready, 1);
    @(posedge clk); #1;

    // R4: write with no configuration since reset
    write_word(32'h11223344);
    idle(3);
    chk(n_err == 1, "R4 unconfigured write error", n_err, 1);
    chk(got.size() == 0, "R4 unconfigured write dropped", got.size(), 0);

    // R5: writes at the strobe edge and one cycle later are dropped
    got.delete(); n_done = 0; n_err = 0;
    cfg_valid = 1'b1; cfg_order = 2'd0; cfg_len_bits = 32'd64;
    wr_valid = 1'b1; wr_data = 32'hDEADBEEF;
    @(posedge clk); #1;
    cfg_valid = 1'b0;
    write_word(32'hCAFEF00D);
    idle(2);
    chk(n_err == 2, "R5 guard-window writes flagged", n_err, 2);
    chk(got.size() == 0, "R5 guard-window writes dropped", got.size(), 0);
    write_word(mk_word(0, 1));
    write_word(mk_word(1, 1));
    wait_done(); idle(2);
    check_stream(0, 8, 1, "R5 after guard");
    chk(n_done == 1, "R5 message completes", n_done, 1);

    // R8: back-pressure holds byte and stalls writes
    rdy_mode = 2;
    configure(1, 64); idle(1);
    write_word(mk_word(0, 2));
    wr_valid = 1'b1; wr_data = mk_word(1, 2);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w0 = mk_word(0, 2);
      @(negedge clk);
      chk(wr_ready == 0 && out_valid == 1, "R8 write stalled while held", wr_ready, 0);
      chk(out_data == w0[31:24], "R8 byte held under stall", out_data, w0[31:24]);
    end
    @(posedge clk); #1;
    rdy_mode = 1;
    write_word(mk_word(1, 2));
    wait_done(); idle(2);
    check_stream(1, 8, 2, "R8 after stall");

    // R10: reconfiguration discards a held word
    rdy_mode = 2;
    configure(0, 64); idle(1);
    write_word(mk_word(0, 7));
    idle(2);
    configure(3, 32);
    chk(out_valid == 0, "R10 held bytes discarded", out_valid, 0);
    rdy_mode = 0;
    idle(1);
    write_word(mk_word(0, 3));
    wait_done(); idle(2);
    check_stream(3, 4, 3, "R10 restart");
    chk(n_done == 1 && n_err == 0, "R10 new message done", n_done, 1);

    // Sweep: mode x byte count x write spacing
    for (int m = 0; m < 4; m++)
      for (int nb = 0; nb < 14; nb++)
        for (int sp = 0; sp < 2; sp++) begin
          rdy_mode = nb % 2;
          run_msg(m, nb, sp[0], m*31 + nb*3 + sp);
        end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule